// File: doc/BRIEF.md
# Dual-Request Memory Latency Model

This block stands in for a shared memory bus that serves a processor's instruction-fetch port and its data port from one word-organised backing array. A request is accepted only while the model is idle. The model then counts a configurable number of delay cycles and presents the result for one cycle. The delay depends on how many ports ask at once. When both the fetch port and the data port request in the same cycle, the model waits the full latency. When only one port requests, it waits half of it.

A pipeline connects the single `stall` output to all of its pipeline registers and advances only when `stall` is low. The fetch enable is normally tied high, so a new fetch starts whenever the model is free. Each accepted request is copied into holding registers, so the requester may change its inputs as soon as the start cycle has passed.

The model has no valid/ready handshake. Back-pressure is one rule: a request that arrives while a transaction is in flight, or in the cycle that transaction completes, is not taken. The requester must hold it until the model is idle again. Read data and the fetched instruction carry meaning only in the cycle their valid flag is high.

Top module: `membus_latency_model`

## Requirements
- R1: A fetch-only request (`ifetch_en`=1, no data strobe) accepted in cycle t raises `ivalid` in cycle t+FULL_LAT/2, with `instr` holding the word at word index `pc[IDX_W+1:2]`. `dvalid` stays low.
- R2: A data-only request (`dread` or `dwrite`, with `ifetch_en`=0) accepted in cycle t raises `dvalid` in cycle t+FULL_LAT/2. For a read, `rdata` holds the word at index `daddr[IDX_W+1:2]`.
- R3: A fetch and a data request accepted in the same cycle t both complete in cycle t+FULL_LAT. `ivalid` and `dvalid` rise together in that cycle.
- R4: `stall` is high from the start cycle up to the cycle before completion. It is low in the completion cycle and while the model is idle with no request.
- R5: `ivalid` and `dvalid` are one-cycle pulses. Requests present in a completion cycle are not taken. A held request starts in the following cycle.
- R6: Request inputs are captured in the start cycle. Changes to `pc`, `daddr`, `dwdata` and the strobes during the count do not alter the result.
- R7: A word write (`dwrite`=1, `dbyte`=0) replaces all four bytes of the addressed word. `dwrite` takes priority over `dread`. `rdata` reads 0 on the completion of a write.
- R8: A byte write (`dbyte`=1) stores `dwdata[7:0]` into byte lane `daddr[1:0]` only (lane 0 = bits 7:0) and leaves the other three lanes unchanged. A byte-mode read returns the whole containing word.
- R9: Addresses at 0x40000000 and above take the same latency as other addresses. They map to the array through the same index bits.
- R10: After reset, word i of the array holds 0xC0DE0000 | i. `stall`, `ivalid` and `dvalid` are low.
- R11: With FULL_LAT = 0, every request completes in the cycle it is presented, valid flags rise in that cycle, and `stall` never asserts.
- R12: `instr` reads 0 whenever `ivalid` is low, and `rdata` reads 0 whenever `dvalid` is low or the completed access was a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ifetch_en | input | 1 | Instruction fetch request |
| pc | input | 32 | Fetch byte address |
| dread | input | 1 | Data read strobe |
| dwrite | input | 1 | Data write strobe |
| dbyte | input | 1 | Byte-mode flag for the data access |
| daddr | input | 32 | Data byte address |
| dwdata | input | 32 | Write data |
| rdata | output | 32 | Read data, meaningful while dvalid is high |
| instr | output | 32 | Fetched instruction, meaningful while ivalid is high |
| dvalid | output | 1 | Data access complete (one-cycle pulse) |
| ivalid | output | 1 | Fetch complete (one-cycle pulse) |
| stall | output | 1 | A transaction is still counting |

## Verification
Fetch-only, data-only and combined requests are each issued once, so the half and full delay are told apart by the cycle in which the valid pulse appears. Word writes, byte writes to two different lanes and byte-mode reads show whether lane selection and whole-word return are correct. Two further patterns target the capture and hand-off rules. In one, the address and data inputs change to junk right after the start cycle. In the other, a fetch is held continuously, so the second start must fall exactly one cycle after the first completion. A second instance with zero latency checks the same-cycle path, and an I/O-region address checks that the upper region is not treated differently.

// File: rtl/mlm_pkg.sv
package mlm_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = WORD_W / 8;

  typedef struct packed {
    logic              ifetch;
    logic              rd;
    logic              wr;
    logic              bytew;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] wdata;
    logic [WORD_W-1:0] pc;
  } mlm_req_t;

  function automatic logic [WORD_W-1:0] init_word(input int idx);
    return 32'hC0DE_0000 | WORD_W'(idx & 16'hFFFF);
  endfunction

  function automatic logic [7:0] init_byte(input int idx, input int lane);
    return 8'(init_word(idx) >> (8 * lane));
  endfunction
endpackage

// File: rtl/mlm_lat_ctrl.sv
module mlm_lat_ctrl #(
  parameter int FULL_LAT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic req_d,
  output logic take,
  output logic busy,
  output logic done,
  output logic pending
);
  localparam int HALF_LAT = FULL_LAT / 2;
  localparam int CNT_W    = (FULL_LAT < 1) ? 1 : $clog2(FULL_LAT + 1);

  logic [CNT_W-1:0] lat_sel, cnt_q;
  logic             busy_q;

  assign lat_sel = (req_i && req_d) ? CNT_W'(FULL_LAT) : CNT_W'(HALF_LAT);
  assign take    = !busy_q && (req_i || req_d);
  assign done    = (take && lat_sel == '0) || (busy_q && cnt_q == '0);
  assign pending = (take && lat_sel != '0) || (busy_q && cnt_q != '0);
  assign busy    = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (take && lat_sel != '0) begin
      busy_q <= 1'b1;
      cnt_q  <= lat_sel - CNT_W'(1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  // Independent elapsed-cycle counter used only for checking the delay
  logic [CNT_W-1:0] chk_cnt, chk_lat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_cnt <= '0;
      chk_lat <= '0;
    end else if (take) begin
      chk_cnt <= CNT_W'(1);
      chk_lat <= lat_sel;
    end else if (busy_q && !done) begin
      chk_cnt <= chk_cnt + CNT_W'(1);
    end
  end

  // R1, R2, R3: completion lands exactly lat_sel cycles after the start
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && done) |-> (chk_cnt == chk_lat));
endmodule

// File: rtl/mlm_mem.sv
module mlm_mem #(
  parameter int WORDS = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic                      wbyte,
  input  logic [mlm_pkg::WORD_W-1:0] daddr,
  input  logic [mlm_pkg::WORD_W-1:0] wdata,
  input  logic [mlm_pkg::WORD_W-1:0] iaddr,
  output logic [mlm_pkg::WORD_W-1:0] d_word,
  output logic [mlm_pkg::WORD_W-1:0] i_word
);
  import mlm_pkg::*;
  localparam int IDX_W = $clog2(WORDS);

  logic [IDX_W-1:0] d_idx, i_idx;
  assign d_idx = daddr[IDX_W+1:2];
  assign i_idx = iaddr[IDX_W+1:2];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] arr [WORDS];
    logic       lane_we;
    logic [7:0] lane_byte;

    assign lane_we   = we && (!wbyte || daddr[1:0] == 2'(l));
    assign lane_byte = wbyte ? wdata[7:0] : wdata[8*l +: 8];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < WORDS; w++) arr[w] <= init_byte(w, l);
      end else if (lane_we) begin
        arr[d_idx] <= lane_byte;
      end
    end

    assign d_word[8*l +: 8] = arr[d_idx];
    assign i_word[8*l +: 8] = arr[i_idx];
  end
endmodule

// File: rtl/membus_latency_model.sv
module membus_latency_model #(
  parameter int FULL_LAT = 10,
  parameter int WORDS    = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ifetch_en,
  input  logic [31:0] pc,
  input  logic        dread,
  input  logic        dwrite,
  input  logic        dbyte,
  input  logic [31:0] daddr,
  input  logic [31:0] dwdata,
  output logic [31:0] rdata,
  output logic [31:0] instr,
  output logic        dvalid,
  output logic        ivalid,
  output logic        stall
);
  import mlm_pkg::*;

  logic     take, busy, done, pending;
  mlm_req_t live, cap_q, eff;
  logic [WORD_W-1:0] d_word, i_word;

  assign live = '{ifetch: ifetch_en, rd: dread, wr: dwrite, bytew: dbyte,
                  addr: daddr, wdata: dwdata, pc: pc};

  mlm_lat_ctrl #(.FULL_LAT(FULL_LAT)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_i(ifetch_en), .req_d(dread || dwrite),
    .take(take), .busy(busy), .done(done), .pending(pending)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else if (take) cap_q <= live;
  end

  assign eff = busy ? cap_q : live;

  mlm_mem #(.WORDS(WORDS)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .we(done && eff.wr), .wbyte(eff.bytew),
    .daddr(eff.addr), .wdata(eff.wdata), .iaddr(eff.pc),
    .d_word(d_word), .i_word(i_word)
  );

  assign ivalid = done && eff.ifetch;
  assign dvalid = done && (eff.rd || eff.wr);
  assign instr  = ivalid ? i_word : '0;
  assign rdata  = (dvalid && !eff.wr) ? d_word : '0;
  assign stall  = pending;

  // R4: stall can only drop in a completion cycle
  p_stall_ends_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> (ivalid || dvalid));

  // R6: held request does not move while counting
  p_capture_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(cap_q));

  if (FULL_LAT >= 2) begin : g_pulse
    // R5: valid flags last a single cycle
    p_ivalid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ivalid |=> !ivalid);
    p_dvalid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dvalid |=> !dvalid);
  end

  if (FULL_LAT == 0) begin : g_zero
    // R11: zero latency never stalls
    p_zero_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ifetch_en || dread || dwrite) |-> (!stall && (ivalid || dvalid)));
  end
endmodule

// File: tb/sim_membus_latency_model.sv
module sim_membus_latency_model;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ifetch_en = 0, dread = 0, dwrite = 0, dbyte = 0;
  logic [31:0] pc = 0, daddr = 0, dwdata = 0;
  logic [31:0] rdata, instr, rdata1, instr1;
  logic        dvalid, ivalid, stall, dvalid1, ivalid1, stall1;

  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  membus_latency_model #(.FULL_LAT(10), .WORDS(256)) u0 (
    .clk(clk), .rst_n(rst_n), .ifetch_en(ifetch_en), .pc(pc), .dread(dread),
    .dwrite(dwrite), .dbyte(dbyte), .daddr(daddr), .dwdata(dwdata),
    .rdata(rdata), .instr(instr), .dvalid(dvalid), .ivalid(ivalid), .stall(stall));

  membus_latency_model #(.FULL_LAT(0), .WORDS(256)) u1 (
    .clk(clk), .rst_n(rst_n), .ifetch_en(ifetch_en), .pc(pc), .dread(dread),
    .dwrite(dwrite), .dbyte(dbyte), .daddr(daddr), .dwdata(dwdata),
    .rdata(rdata1), .instr(instr1), .dvalid(dvalid1), .ivalid(ivalid1), .stall(stall1));

  function automatic logic [31:0] iw(input int i);
    return 32'hC0DE_0000 | 32'(i);
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drop();
    ifetch_en = 0; dread = 0; dwrite = 0; dbyte = 0;
    pc = 32'hFFFF_FFFC; daddr = 32'hFFFF_FFFC; dwdata = 32'h0;
  endtask

  // One transaction on u0; inputs turn to junk right after the start cycle
  task automatic txn(input logic i, input logic dr, input logic dw, input logic by,
                     input logic [31:0] a, input logic [31:0] wd, input logic [31:0] p,
                     input int exp_lat, input logic exp_iv, input logic exp_dv,
                     input logic [31:0] exp_instr, input logic [31:0] exp_rd,
                     input string req);
    int got = -1;
    logic si = 0, sd = 0, bad_stall = 0, after = 0;
    logic [31:0] sinstr = 0, srd = 0;
    @(negedge clk);
    ifetch_en = i; dread = dr; dwrite = dw; dbyte = by; daddr = a; dwdata = wd; pc = p;
    #1;
    for (int k = 0; k < 40; k++) begin
      if (got >= 0) begin
        after = ivalid | dvalid;
        break;
      end
      if (ivalid || dvalid) begin
        got = k; si = ivalid; sd = dvalid; sinstr = instr; srd = rdata;
        if (stall) bad_stall = 1;
      end else if (!stall) bad_stall = 1;
      @(negedge clk);
      if (k == 0) drop();
      #1;
    end
    drop();
    chk(got == exp_lat, req, "latency", 32'(got), 32'(exp_lat));
    chk(si == exp_iv && sd == exp_dv, req, "valid pair", {30'b0, si, sd}, {30'b0, exp_iv, exp_dv});
    chk(sinstr == exp_instr, req, "instr", sinstr, exp_instr);
    chk(srd == exp_rd, req, "rdata (R6 capture)", srd, exp_rd);
    chk(!bad_stall, "R4", "stall profile", 32'(bad_stall), 32'h0);
    chk(!after, "R5", "pulse after completion", 32'(after), 32'h0);
  endtask

  task automatic t_reset();
    #1;
    chk(!stall && !ivalid && !dvalid, "R10", "idle flags", {29'b0, stall, ivalid, dvalid}, 32'h0);
    chk(instr == 0 && rdata == 0, "R12", "outputs zero when idle", instr | rdata, 32'h0);
  endtask

  task automatic t_single();
    txn(1, 0, 0, 0, 32'h0, 32'h0, 32'h10, 5, 1, 0, iw(4), 0, "R1");
    txn(0, 1, 0, 0, 32'h20, 32'h0, 32'h0, 5, 0, 1, 0, iw(8), "R2");
  endtask

  task automatic t_both();
    txn(1, 1, 0, 0, 32'h3FC, 32'h0, 32'h0, 10, 1, 1, iw(0), iw(255), "R3");
  endtask

  task automatic t_writes();
    txn(0, 1, 1, 0, 32'h40, 32'hDEAD_BEEF, 32'h0, 5, 0, 1, 0, 0, "R7");
    txn(0, 1, 0, 0, 32'h40, 32'h0, 32'h0, 5, 0, 1, 0, 32'hDEAD_BEEF, "R7");
    txn(0, 0, 1, 1, 32'h42, 32'hAAAA_AA77, 32'h0, 5, 0, 1, 0, 0, "R8");
    txn(0, 0, 1, 1, 32'h40, 32'h1234_5611, 32'h0, 5, 0, 1, 0, 0, "R8");
    txn(0, 1, 0, 1, 32'h43, 32'h0, 32'h0, 5, 0, 1, 0, 32'hDE77_BE11, "R8");
  endtask

  task automatic t_io();
    txn(0, 1, 0, 0, 32'h4000_0020, 32'h0, 32'h0, 5, 0, 1, 0, iw(8), "R9");
    txn(1, 1, 0, 0, 32'h4000_0030, 32'h0, 32'h4, 10, 1, 1, iw(1), iw(12), "R9");
  endtask

  task automatic t_back2back();
    logic [12:0] seen = '0;
    @(negedge clk);
    ifetch_en = 1; pc = 32'h8;
    #1;
    for (int k = 0; k < 13; k++) begin
      seen[k] = ivalid;
      @(negedge clk); #1;
    end
    drop();
    chk(seen == 13'b0_1000_0010_0000, "R5", "held fetch completion cycles", 32'(seen), 32'h0820);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_zero();
    @(negedge clk);
    ifetch_en = 1; pc = 32'h14; dread = 1; daddr = 32'h18;
    #1;
    chk(ivalid1 && dvalid1 && !stall1, "R11", "same-cycle flags", {29'b0, stall1, ivalid1, dvalid1}, 32'h3);
    chk(instr1 == iw(5) && rdata1 == iw(6), "R11", "same-cycle data", instr1 ^ rdata1, iw(5) ^ iw(6));
    @(negedge clk);
    ifetch_en = 0; dread = 0; dwrite = 1; daddr = 32'h18; dwdata = 32'h55AA_55AA;
    #1;
    chk(dvalid1 && !stall1 && rdata1 == 0, "R11", "zero-latency write", rdata1, 32'h0);
    @(negedge clk);
    dwrite = 0; dread = 1;
    #1;
    chk(rdata1 == 32'h55AA_55AA && !stall1, "R11", "read back", rdata1, 32'h55AA_55AA);
    @(negedge clk);
    drop();
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    drop();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_both();
    t_writes();
    t_io();
    t_back2back();
    t_zero();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule